// File: doc/BRIEF.md
# Configuration Access Filter and Router

This block stands at the entry of a root port's configuration path. Each configuration read or write arrives as a single-cycle request that carries a bus, device and function number, a byte offset, an access size, a read/write flag, write data and the current link-active state. The block makes one of three decisions for each request:

- Answer it locally. A read gets all-ones, and a write is dropped.
- Send it to the root port's own memory-mapped register space.
- Forward it to the packet builder that serves downstream devices.

The block holds the root bus number as internal state. This number starts from a parameter at reset. Afterwards the block follows it by watching root-port writes to the primary bus register. Several accesses are answered locally:

- The root port's first base address register is hidden from enumeration.
- Each of the first two bus levels allows only device 0.
- No request reaches a downstream bus while the link is down.

The decision appears one cycle after the request. A locally answered access also returns a done response in that same cycle.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, `route_valid`, `resp_valid` and `resp_data` are 0, and the root bus number equals the parameter `RESET_ROOT_BUS` (default 0).
- R2: Each cycle with `req_valid` high produces exactly one `route_valid` pulse in the next cycle. A cycle without a request produces no `route_valid` and no `resp_valid` in the next cycle.
- R3: A valid access whose bus equals the root bus number is routed to the root-port register space (`route_sel` = 2'b01).
- R4: A valid access to any other bus is routed to the packet path (`route_sel` = 2'b10).
- R5: When `HIDE_BAR0` is 1, an access to the root bus, device 0, function 0, offset `BAR0_OFF` (0x10) is answered locally (`route_sel` = 2'b00) for both reads and writes.
- R6: An access to a bus other than the root bus while `link_active` is 0 is answered locally (`route_sel` = 2'b00).
- R7: An access to the root bus, or to the root bus + 1 (modulo 256), with a device number other than 0 is answered locally (`route_sel` = 2'b00). Device 0 on root + 1 is valid.
- R8: `resp_valid` pulses together with `route_valid` only for locally answered accesses. For a read, `resp_data` is all-ones of the access size: `req_size` 2'b00 gives 0x000000FF, 2'b01 gives 0x0000FFFF, and 2'b10 or 2'b11 give 0xFFFFFFFF. For a write, `resp_data` is 0.
- R9: A write routed to the root-port register space at offset `PRIBUS_OFF` (0x18) loads `req_wdata[7:0]` as the root bus number, and the new value is used from the next request on. Reads, and writes that are hidden, invalid or at other offsets, leave the root bus number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_offset | input | 12 | Configuration byte offset |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| link_active | input | 1 | Data link layer active status |
| route_valid | output | 1 | Routing decision strobe |
| route_sel | output | 2 | 00 local answer, 01 root-port registers, 10 packet path |
| resp_valid | output | 1 | Done strobe for locally answered accesses |
| resp_data | output | 32 | Synthetic read data |

## Verification
The assertions check on every cycle the following properties against the internally held root bus number:

- Every request gets exactly one decision, and idle cycles get none.
- Link-down downstream accesses, extra devices on the root bus, and the hidden base address register always end up answered locally.
- A primary-bus write loads its low data byte, and no other cycle changes the bus number.

Only the bench's scenarios can show a few other behaviours:

- The all-ones widths for each access size.
- The sequence effect of moving the root bus, which changes which later accesses count as root or downstream.
- The wrap of root + 1 at bus 255.
- The split between the packet path and the root-port register space across random traffic.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
   typedef enum logic [1:0] {
      RT_LOCAL   = 2'b00,
      RT_ROOTREG = 2'b01,
      RT_PACKET  = 2'b10
   } route_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/cfgr_classify.sv
module cfgr_classify
   import cfgr_pkg::*;
#(
   parameter int BUS_W     = 8,
   parameter int DEV_W     = 5,
   parameter int FN_W      = 3,
   parameter int OFF_W     = 12,
   parameter bit HIDE_BAR0 = 1'b1,
   parameter int BAR0_OFF  = 'h10,
   parameter int PRIBUS_OFF = 'h18
) (
   input  logic             req_valid,
   input  logic [BUS_W-1:0] req_bus,
   input  logic [DEV_W-1:0] req_dev,
   input  logic [FN_W-1:0]  req_fn,
   input  logic [OFF_W-1:0] req_offset,
   input  logic             req_write,
   input  logic             link_active,
   input  logic [BUS_W-1:0] root_bus,
   output route_e           route,
   output logic             load_root
);
   localparam logic [OFF_W-1:0] BAR0_A   = OFF_W'(BAR0_OFF);
   localparam logic [OFF_W-1:0] PRIBUS_A = OFF_W'(PRIBUS_OFF);

   logic on_root, on_next, hidden, invalid, answer_here;

   assign on_root = (req_bus == root_bus);
   assign on_next = (req_bus == BUS_W'(root_bus + 1'b1));

   generate
      if (HIDE_BAR0) begin : g_hide
         assign hidden = on_root && (req_dev == '0) && (req_fn == '0) &&
                         (req_offset == BAR0_A);
      end else begin : g_nohide
         assign hidden = 1'b0;
      end
   endgenerate

   assign invalid = (!on_root && !link_active) ||
                    (on_root && (req_dev != '0)) ||
                    (on_next && (req_dev != '0));

   assign answer_here = hidden || invalid;

   always_comb begin
      if (answer_here)  route = RT_LOCAL;
      else if (on_root) route = RT_ROOTREG;
      else              route = RT_PACKET;
   end

   assign load_root = req_valid && req_write && (route == RT_ROOTREG) &&
                      (req_offset == PRIBUS_A);
endmodule

// File: rtl/cfgr_bus_track.sv
module cfgr_bus_track #(
   parameter int BUS_W          = 8,
   parameter int RESET_ROOT_BUS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BUS_W-1:0] new_bus,
   output logic [BUS_W-1:0] root_bus
);
   always_ff @(posedge clk) begin
      if (!rst_n)    root_bus <= BUS_W'(RESET_ROOT_BUS);
      else if (load) root_bus <= new_bus;
   end
endmodule

// File: rtl/cfgr_resp_gen.sv
module cfgr_resp_gen
   import cfgr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  route_e            route,
   output logic              route_valid,
   output logic [1:0]        route_sel,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data
);
   localparam logic [DATA_W-1:0] ONES_B = {{(DATA_W-8){1'b0}}, 8'hFF};
   localparam logic [DATA_W-1:0] ONES_H = {{(DATA_W-16){1'b0}}, 16'hFFFF};

   logic [DATA_W-1:0] fill;

   always_comb begin
      case (req_size)
         SZ_BYTE: fill = ONES_B;
         SZ_HALF: fill = ONES_H;
         default: fill = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_sel   <= RT_LOCAL;
         resp_valid  <= 1'b0;
         resp_data   <= '0;
      end else begin
         route_valid <= req_valid;
         route_sel   <= req_valid ? route : RT_LOCAL;
         resp_valid  <= req_valid && (route == RT_LOCAL);
         if (req_valid && (route == RT_LOCAL))
            resp_data <= req_write ? '0 : fill;
         else
            resp_data <= '0;
      end
   end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
   import cfgr_pkg::*;
#(
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int FN_W           = 3,
   parameter int OFF_W          = 12,
   parameter int DATA_W         = 32,
   parameter int RESET_ROOT_BUS = 0,
   parameter bit HIDE_BAR0      = 1'b1,
   parameter int BAR0_OFF       = 'h10,
   parameter int PRIBUS_OFF     = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_fn,
   input  logic [OFF_W-1:0]  req_offset,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              link_active,
   output logic              route_valid,
   output logic [1:0]        route_sel,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data
);
   generate
      if (DATA_W < 16 || DATA_W < BUS_W)
         $error("cfg_access_router: DATA_W too narrow");
      if (BAR0_OFF >= (1 << OFF_W) || PRIBUS_OFF >= (1 << OFF_W))
         $error("cfg_access_router: offsets exceed OFF_W");
      if (RESET_ROOT_BUS >= (1 << BUS_W))
         $error("cfg_access_router: RESET_ROOT_BUS exceeds BUS_W");
   endgenerate

   logic [BUS_W-1:0] root_q;
   route_e           route;
   logic             load_root;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^req_wdata[DATA_W-1:BUS_W];

   cfgr_classify #(
      .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
      .HIDE_BAR0(HIDE_BAR0), .BAR0_OFF(BAR0_OFF), .PRIBUS_OFF(PRIBUS_OFF)
   ) u_class (
      .req_valid(req_valid), .req_bus(req_bus), .req_dev(req_dev),
      .req_fn(req_fn), .req_offset(req_offset), .req_write(req_write),
      .link_active(link_active), .root_bus(root_q),
      .route(route), .load_root(load_root)
   );

   cfgr_bus_track #(
      .BUS_W(BUS_W), .RESET_ROOT_BUS(RESET_ROOT_BUS)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .load(load_root),
      .new_bus(req_wdata[BUS_W-1:0]), .root_bus(root_q)
   );

   cfgr_resp_gen #(
      .DATA_W(DATA_W)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_write(req_write), .req_size(req_size), .route(route),
      .route_valid(route_valid), .route_sel(route_sel),
      .resp_valid(resp_valid), .resp_data(resp_data)
   );
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
   parameter int BUS_W      = 8,
   parameter int DEV_W      = 5,
   parameter int FN_W       = 3,
   parameter int OFF_W      = 12,
   parameter int DATA_W     = 32,
   parameter bit HIDE_BAR0  = 1'b1,
   parameter int BAR0_OFF   = 'h10,
   parameter int PRIBUS_OFF = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [BUS_W-1:0]  req_bus,
   input logic [DEV_W-1:0]  req_dev,
   input logic [FN_W-1:0]   req_fn,
   input logic [OFF_W-1:0]  req_offset,
   input logic              req_write,
   input logic [DATA_W-1:0] req_wdata,
   input logic              link_active,
   input logic              route_valid,
   input logic [1:0]        route_sel,
   input logic              resp_valid,
   input logic [BUS_W-1:0]  root_q
);
   p_one_decision_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> route_valid);

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!route_valid && !resp_valid));

   p_link_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !link_active && req_bus != root_q)
      |=> (route_sel == 2'b00 && resp_valid));

   p_root_extra_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bus == root_q && req_dev != '0)
      |=> (route_sel == 2'b00 && resp_valid));

   p_hidden_bar_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (HIDE_BAR0 && req_valid && req_bus == root_q && req_dev == '0 &&
       req_fn == '0 && req_offset == OFF_W'(BAR0_OFF))
      |=> (route_sel == 2'b00 && resp_valid));

   p_root_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_bus == root_q && req_dev == '0 &&
       req_offset == OFF_W'(PRIBUS_OFF))
      |=> (root_q == $past(req_wdata[BUS_W-1:0])));

   p_root_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(root_q));

   p_resp_local_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (route_valid && route_sel == 2'b00));
endmodule

bind cfg_access_router cfgr_checker #(
   .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
   .DATA_W(DATA_W), .HIDE_BAR0(HIDE_BAR0), .BAR0_OFF(BAR0_OFF),
   .PRIBUS_OFF(PRIBUS_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
   .req_dev(req_dev), .req_fn(req_fn), .req_offset(req_offset),
   .req_write(req_write), .req_wdata(req_wdata),
   .link_active(link_active), .route_valid(route_valid),
   .route_sel(route_sel), .resp_valid(resp_valid), .root_q(root_q)
);

// File: tb/cfg_access_router_test.sv
module cfg_access_router_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_fn = '0;
   logic [11:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        link_active = 1'b0;
   logic        route_valid;
   logic [1:0]  route_sel;
   logic        resp_valid;
   logic [31:0] resp_data;

   int total = 0;
   int bad = 0;
   logic [7:0] root_m = 8'd0;

   always #5 clk = ~clk;

   cfg_access_router uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
      .req_dev(req_dev), .req_fn(req_fn), .req_offset(req_offset),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .link_active(link_active), .route_valid(route_valid),
      .route_sel(route_sel), .resp_valid(resp_valid), .resp_data(resp_data)
   );

   function automatic logic [1:0] exp_route(input logic [7:0] b,
      input logic [4:0] d, input logic [2:0] f, input logic [11:0] o,
      input logic lk);
      logic is_r, is_n;
      is_r = (b == root_m);
      is_n = (b == 8'(root_m + 8'd1));
      if (is_r && d == 0 && f == 0 && o == 12'h010) return 2'b00;
      if (!is_r && !lk) return 2'b00;
      if ((is_r || is_n) && d != 0) return 2'b00;
      return is_r ? 2'b01 : 2'b10;
   endfunction

   function automatic logic [31:0] exp_data(input logic [1:0] sz,
      input logic wr);
      if (wr) return 32'h0;
      case (sz)
         2'b00:   return 32'h0000_00FF;
         2'b01:   return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic check(input string tag, input logic [35:0] act,
      input logic [35:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got {rv,sel,resp,data}=%h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input string tag, input logic [7:0] b,
      input logic [4:0] d, input logic [2:0] f, input logic [11:0] o,
      input logic [1:0] sz, input logic wr, input logic [31:0] wd,
      input logic lk);
      logic [1:0] er;
      logic [31:0] ed;
      req_valid = 1'b1; req_bus = b; req_dev = d; req_fn = f;
      req_offset = o; req_size = sz; req_write = wr; req_wdata = wd;
      link_active = lk;
      er = exp_route(b, d, f, o, lk);
      ed = (er == 2'b00) ? exp_data(sz, wr) : 32'h0;
      @(negedge clk);
      check(tag, {1'b1, route_sel, resp_valid, resp_data},
            {1'b1, er, (er == 2'b00), ed});
      if (route_valid !== 1'b1) begin
         total++; bad++;
         $display("FAIL R2: route_valid=%b expected 1", route_valid);
      end
      if (er == 2'b01 && wr && o == 12'h018) root_m = wd[7:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {route_valid, route_sel, resp_valid, resp_data}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle after reset", {route_valid, route_sel, resp_valid, resp_data}, 36'h0);
      // R1/R3: root bus starts at 0
      access("R1 R3 root dev0 read", 8'd0, 5'd0, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b0);
      access("R3 root fn1 bar0 offset", 8'd0, 5'd0, 3'd1, 12'h010, 2'b10, 1'b0, 0, 1'b0);
      // R5 hidden base register at every size
      access("R5 R8 hidden word read", 8'd0, 5'd0, 3'd0, 12'h010, 2'b10, 1'b0, 0, 1'b1);
      access("R5 R8 hidden byte read", 8'd0, 5'd0, 3'd0, 12'h010, 2'b00, 1'b0, 0, 1'b1);
      access("R5 R8 hidden half read", 8'd0, 5'd0, 3'd0, 12'h010, 2'b01, 1'b0, 0, 1'b1);
      access("R5 hidden write dropped", 8'd0, 5'd0, 3'd0, 12'h010, 2'b10, 1'b1, 32'h1234, 1'b1);
      // R7 single device per level
      access("R7 root dev3", 8'd0, 5'd3, 3'd0, 12'h000, 2'b11, 1'b0, 0, 1'b1);
      access("R7 next dev2", 8'd1, 5'd2, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b1);
      access("R4 R7 next dev0", 8'd1, 5'd0, 3'd0, 12'h004, 2'b10, 1'b0, 0, 1'b1);
      access("R4 deeper bus dev5", 8'd2, 5'd5, 3'd2, 12'h008, 2'b10, 1'b1, 32'h55, 1'b1);
      // R6 link down
      access("R6 link down next", 8'd1, 5'd0, 3'd0, 12'h000, 2'b01, 1'b0, 0, 1'b0);
      access("R6 link down deep write", 8'd9, 5'd0, 3'd0, 12'h000, 2'b10, 1'b1, 32'h9, 1'b0);
      // R9 bus number tracking
      access("R9 read primary no load", 8'd0, 5'd0, 3'd0, 12'h018, 2'b10, 1'b0, 0, 1'b1);
      access("R9 root unchanged", 8'd0, 5'd0, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b1);
      access("R9 invalid write no load", 8'd0, 5'd1, 3'd0, 12'h018, 2'b10, 1'b1, 32'h77, 1'b1);
      access("R9 primary write", 8'd0, 5'd0, 3'd0, 12'h018, 2'b10, 1'b1, 32'hAB05, 1'b1);
      access("R9 new root used", 8'd5, 5'd0, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b0);
      access("R9 old root downstream", 8'd0, 5'd0, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b1);
      access("R9 R5 hidden follows root", 8'd5, 5'd0, 3'd0, 12'h010, 2'b00, 1'b0, 0, 1'b1);
      // R7 wrap of root + 1 at bus 255
      access("R9 move root to 255", 8'd5, 5'd0, 3'd0, 12'h018, 2'b00, 1'b1, 32'hFF, 1'b1);
      access("R7 wrap bus0 dev1", 8'd0, 5'd1, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b1);
      access("R4 wrap bus0 dev0", 8'd0, 5'd0, 3'd0, 12'h000, 2'b10, 1'b0, 0, 1'b1);
      // R2 idle cycle
      req_valid = 1'b0;
      @(negedge clk);
      check("R2 no request no pulse", {route_valid, route_sel, resp_valid, resp_data}, 36'h0);
      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] b;
         logic [4:0] d;
         logic [11:0] o;
         int sel;
         sel = int'($urandom_range(0, 3));
         case (sel)
            0: b = root_m;
            1: b = 8'(root_m + 8'd1);
            2: b = 8'(root_m + 8'd2);
            default: b = 8'($urandom);
         endcase
         d = ($urandom_range(0, 2) == 0) ? 5'($urandom) : 5'd0;
         case ($urandom_range(0, 3))
            0: o = 12'h010;
            1: o = 12'h018;
            default: o = 12'($urandom);
         endcase
         access("R3 R4 R5 R6 R7 R8 R9 random", b, d, 3'($urandom_range(0, 1)), o,
                2'($urandom), 1'($urandom), $urandom, ($urandom_range(0, 3) != 0));
         if ($urandom_range(0, 9) == 0) begin
            req_valid = 1'b0;
            @(negedge clk);
            check("R2 random idle", {route_valid, resp_valid}, 36'h0);
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule